// File: doc/BRIEF.md
# RTC Byte Command Bridge

This block sits on the processor's register bus and gives software a byte-wide path into registers that live in an always-on timekeeping domain. Software frames each transaction itself. It sets a select bit in the control register, then pushes bytes one at a time through the data register. It polls a busy flag between bytes. Each write to the data register starts one full-duplex byte exchange on a three-wire serial link (select, clock, data out) plus a return data line. When the flag drops, the byte that came back can be read from the same data register.

A transaction begins with a command byte: bit 7 set means write and bit 7 clear means read, and bits 6:0 hold the target address. Then come one payload byte for an 8-bit configuration register, or four payload bytes, most significant first, for a 32-bit counter or alarm value. A read sends zero bytes and collects what returns. The bridge passes every byte through unchanged. The whole framing lives in software, and the hardware handles only a single byte exchange and the select line.

Top module: `rtc_byte_bridge`

## Requirements
- R1: After reset, rtc_cs_n is 1, rtc_sclk is 0, rtc_mosi is 0, the busy flag (control bit 1) is 0 and the data register reads 0.
- R2: Control bit 0 is the select bit. It is read/write, it reads back as written, and rtc_cs_n equals its inverse from the cycle after the write.
- R3: A bus write to the data register (bus_addr = 1) while idle sets the busy flag from the next cycle on. The flag stays set for exactly 16*HALF_DIV cycles and then clears.
- R4: The low 8 bits of the written value leave on rtc_mosi most significant bit first. rtc_mosi changes only on a falling edge of rtc_sclk while a transfer runs.
- R5: Each transfer makes exactly 8 rising rtc_sclk edges. rtc_sclk idles low, and each clock phase lasts HALF_DIV system cycles.
- R6: rtc_miso is sampled on each rising rtc_sclk edge, and the first sample becomes bit 7. Once busy clears, the data register returns the received byte in bits 7:0.
- R7: A data register write while busy is ignored: the running byte, its length and the received byte are unaffected.
- R8: Data register bits above 7 read as 0. The received byte holds unchanged while a transfer runs and until the next one completes.
- R9: Successive bytes sent with the select bit held keep rtc_cs_n low across the whole frame, so a command byte plus four payload bytes forms one transaction in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| rtc_cs_n | output | 1 | Active-low frame select toward the RTC domain |
| rtc_sclk | output | 1 | Serial clock, idle low |
| rtc_mosi | output | 1 | Serial data toward the RTC domain |
| rtc_miso | input | 1 | Serial data from the RTC domain |

## Verification
The bench builds the bridge with HALF_DIV = 3, which selects the counter-based phase divider and makes every phase three cycles long. This lets the bench count the exact busy window of 48 cycles and catch a divider that is off by one. DATA_W stays at 32, so the zero upper bits of the data register are checked. A behavioural RTC model on the serial pins echoes chosen bytes. With it the bench covers single bytes, a write rejected mid-transfer, and complete 32-bit write and read frames with command bytes.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
   typedef enum logic {
      REG_CTRL = 1'b0,
      REG_DATA = 1'b1
   } rtcb_reg_e;

   localparam int CTRL_SEL_BIT  = 0;
   localparam int CTRL_BUSY_BIT = 1;
endpackage

// File: rtl/rtcb_halftick.sv
module rtcb_halftick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("rtcb_halftick: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rtcb_shifter.sv
module rtcb_shifter #(
   parameter int BYTE_W   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("rtcb_shifter: BYTE_W must be at least 2");
      end
   endgenerate

   logic              busy_q;
   logic              sclk_q;
   logic [BYTE_W-1:0] tx_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BIT_W-1:0]  bit_q;
   logic              tick;

   rtcb_halftick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            tx_q   <= tx_byte;
            bit_q  <= '0;
         end
      end else if (tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[BYTE_W-2:0], miso};
         end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            if (bit_q == LAST_BIT) begin
               busy_q <= 1'b0;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign sclk    = sclk_q;
   assign mosi    = tx_q[BYTE_W-1];
   assign done    = busy_q && tick && sclk_q && (bit_q == LAST_BIT);
   assign rx_byte = rx_q;
endmodule

// File: rtl/rtcb_regs.sv
module rtcb_regs
   import rtcb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              start,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              sel,
   output logic [BYTE_W-1:0] rd_byte
);
   generate
      if (DATA_W < BYTE_W || DATA_W < 2) begin : g_bad_dw
         $error("rtcb_regs: DATA_W must cover BYTE_W and two control bits");
      end
   endgenerate

   logic              sel_q;
   logic [BYTE_W-1:0] rd_q;
   logic              wr_ctrl;
   logic              wr_data;

   assign wr_ctrl = bus_req && bus_we && (bus_addr == REG_CTRL);
   assign wr_data = bus_req && bus_we && (bus_addr == REG_DATA);
   assign start   = wr_data && !busy;
   assign tx_byte = bus_wdata[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         rd_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            sel_q <= bus_wdata[CTRL_SEL_BIT];
         end
         if (done) begin
            rd_q <= rx_byte;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == REG_CTRL) begin
         bus_rdata[CTRL_SEL_BIT]  = sel_q;
         bus_rdata[CTRL_BUSY_BIT] = busy;
      end else begin
         bus_rdata[BYTE_W-1:0] = rd_q;
      end
   end

   assign sel     = sel_q;
   assign rd_byte = rd_q;
endmodule

// File: rtl/rtc_byte_bridge.sv
module rtc_byte_bridge #(
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rtc_cs_n,
   output logic              rtc_sclk,
   output logic              rtc_mosi,
   input  logic              rtc_miso
);
   logic              busy_w;
   logic              done_w;
   logic              start_w;
   logic              sel_w;
   logic [BYTE_W-1:0] tx_w;
   logic [BYTE_W-1:0] rx_w;
   logic [BYTE_W-1:0] rd_byte_w;

   rtcb_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .busy     (busy_w),
      .done     (done_w),
      .rx_byte  (rx_w),
      .start    (start_w),
      .tx_byte  (tx_w),
      .sel      (sel_w),
      .rd_byte  (rd_byte_w)
   );

   rtcb_shifter #(.BYTE_W(BYTE_W), .HALF_DIV(HALF_DIV)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_w),
      .tx_byte(tx_w),
      .miso   (rtc_miso),
      .busy   (busy_w),
      .sclk   (rtc_sclk),
      .mosi   (rtc_mosi),
      .done   (done_w),
      .rx_byte(rx_w)
   );

   assign rtc_cs_n = !sel_w;
endmodule

// File: rtl/rtcb_checker.sv
module rtcb_checker #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cs_n,
   input logic              sclk,
   input logic              mosi,
   input logic              busy,
   input logic [BYTE_W-1:0] rd_byte
);
   // R2: the select line follows the written control bit
   a_r2_cs_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_addr) |=> (cs_n == !$past(bus_wdata[0])));

   // R3: an idle data write raises busy
   a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr && !busy) |=> busy);

   // R5: the serial clock rests low when nothing moves
   a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R4: data out moves only on a falling serial clock mid-transfer
   a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

   // R8: received byte is frozen during a transfer
   a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rd_byte));

   // R8: high bits of the data register read as zero
   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr |-> (bus_rdata[DATA_W-1:BYTE_W] == '0));
endmodule

bind rtc_byte_bridge rtcb_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .cs_n     (rtc_cs_n),
   .sclk     (rtc_sclk),
   .mosi     (rtc_mosi),
   .busy     (busy_w),
   .rd_byte  (rd_byte_w)
);

// File: tb/rtc_byte_bridge_tb.sv
`timescale 1ns/1ps
module rtc_byte_bridge_tb_top;
   localparam int DW   = 32;
   localparam int HALF = 3;
   localparam int XFER = 16 * HALF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_addr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          cs_n, sclk, mosi, miso;

   int checks = 0;
   int errors = 0;

   logic [7:0] s_resp = 8'h00;
   logic [7:0] s_cap  = 8'h00;
   int         s_bit  = 0;
   int         s_rises = 0;

   always #10 clk = ~clk;

   rtc_byte_bridge #(.DATA_W(DW), .BYTE_W(8), .HALF_DIV(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rtc_cs_n(cs_n), .rtc_sclk(sclk), .rtc_mosi(mosi), .rtc_miso(miso)
   );

   // behavioural RTC-side model: captures on rising, presents next bit after it
   always_comb miso = (s_bit < 8) ? s_resp[7 - s_bit] : 1'b0;
   always @(posedge sclk) begin
      s_cap   <= {s_cap[6:0], mosi};
      s_bit   <= s_bit + 1;
      s_rises <= s_rises + 1;
   end

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd_now(input logic a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // one byte exchange with exact busy-window timing; returns received byte
   task automatic xfer(input logic [7:0] tx, input logic [7:0] resp, output logic [7:0] rx);
      logic [DW-1:0] r;
      s_resp = resp; s_bit = 0; s_rises = 0;
      bus_wr(1'b1, {24'hFFFFFF, tx});
      rd_now(1'b0, r); check("R3 busy set", DW'(r[1]), 1);
      repeat (XFER - 1) @(posedge clk);
      @(negedge clk);
      rd_now(1'b0, r); check("R3 busy still set", DW'(r[1]), 1);
      @(posedge clk); @(negedge clk);
      rd_now(1'b0, r); check("R3 busy cleared", DW'(r[1]), 0);
      check("R4 byte out msb first", DW'(s_cap), DW'(tx));
      check("R5 eight rising edges", DW'(s_rises), 8);
      check("R5 sclk idle low", DW'(sclk), 0);
      rd_now(1'b1, r);
      check("R6 received byte", r, DW'(resp));
      rx = r[7:0];
   endtask

   task automatic t_reset();
      logic [DW-1:0] r;
      check("R1 cs_n", DW'(cs_n), 1);
      check("R1 sclk", DW'(sclk), 0);
      check("R1 mosi", DW'(mosi), 0);
      rd_now(1'b0, r); check("R1 ctrl", r, 0);
      rd_now(1'b1, r); check("R1 data", r, 0);
   endtask

   task automatic t_select();
      logic [DW-1:0] r;
      bus_wr(1'b0, 32'h1);
      check("R2 cs low", DW'(cs_n), 0);
      rd_now(1'b0, r); check("R2 sel readback", r, 1);
      bus_wr(1'b0, 32'h0);
      check("R2 cs high", DW'(cs_n), 1);
      rd_now(1'b0, r); check("R2 sel cleared", r, 0);
   endtask

   task automatic t_bytes();
      logic [7:0] rx;
      bus_wr(1'b0, 32'h1);
      xfer(8'hA5, 8'h3C, rx);
      xfer(8'h01, 8'h80, rx);
      xfer(8'hFE, 8'h7F, rx);
      bus_wr(1'b0, 32'h0);
   endtask

   task automatic t_ignore_busy();
      logic [DW-1:0] r;
      bus_wr(1'b0, 32'h1);
      s_resp = 8'h96; s_bit = 0; s_rises = 0;
      bus_wr(1'b1, 32'h0000_00C3);
      repeat (4) @(posedge clk);
      bus_wr(1'b1, 32'h0000_0055);
      repeat (XFER - 1 - 5) @(posedge clk);
      @(negedge clk);
      rd_now(1'b0, r); check("R7 length unchanged busy", DW'(r[1]), 1);
      @(posedge clk); @(negedge clk);
      rd_now(1'b0, r); check("R7 length unchanged idle", DW'(r[1]), 0);
      check("R7 byte unchanged", DW'(s_cap), 32'hC3);
      check("R7 edges unchanged", DW'(s_rises), 8);
      rd_now(1'b1, r); check("R7 rx unchanged", r, 32'h96);
      repeat (10) @(posedge clk); @(negedge clk);
      rd_now(1'b1, r); check("R8 rx held", r, 32'h96);
      check("R8 upper bits zero", DW'(r[DW-1:8]), 0);
      bus_wr(1'b0, 32'h0);
   endtask

   task automatic t_frame_write32(input logic [6:0] addr, input logic [31:0] val);
      logic [7:0] rx;
      bus_wr(1'b0, 32'h1);
      xfer({1'b1, addr}, 8'h00, rx);
      check("R9 cs held after cmd", DW'(cs_n), 0);
      for (int i = 3; i >= 0; i--) begin
         xfer(val[i*8 +: 8], 8'h00, rx);
         check("R9 cs held in write frame", DW'(cs_n), 0);
      end
      bus_wr(1'b0, 32'h0);
      check("R9 cs released", DW'(cs_n), 1);
   endtask

   task automatic t_frame_read32(input logic [6:0] addr, input logic [31:0] val);
      logic [7:0]  rx;
      logic [31:0] got = '0;
      bus_wr(1'b0, 32'h1);
      xfer({1'b0, addr}, 8'h00, rx);
      for (int i = 3; i >= 0; i--) begin
         xfer(8'h00, val[i*8 +: 8], rx);
         got = {got[23:0], rx};
         check("R9 cs held in read frame", DW'(cs_n), 0);
      end
      check("R9 assembled 32-bit read", got, val);
      bus_wr(1'b0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_bytes();
      t_ignore_busy();
      t_frame_write32(7'h12, 32'h6013_4B80);
      t_frame_read32(7'h12, 32'hA1B2_C3D4);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule